// File: doc/BRIEF.md
# Memory-Mapped Terminal I/O Port

This block sits on a processor's load/store bus as a slave and exposes a one-character keyboard receiver and a one-character display transmitter. There are four word-sized registers: a control word and a data word for each direction. Software checks a ready flag in each control word before moving a character. It can also set an enable bit so that the same flag raises a level interrupt request instead of being polled.

On the receive side, the keyboard logic presents a byte with a one-cycle strobe. The byte is held until the processor reads the receiver data word, and that read lowers the ready flag. If a new keystroke lands before the held byte was consumed, the byte is replaced and a sticky overrun flag is set. On the transmit side, a write to the transmitter data word emits a one-cycle strobe carrying the character toward the display. Ready then stays low until the display's busy line is seen low again. Bus reads are combinational: read data is valid in the same cycle as the read strobe, and any side effect of the read takes place at the closing clock edge.

Top module: `term_mmio`

## Requirements
- R1: The four registers decode at word offsets from parameter BASE (default 0xFFFF0000): receiver control at +0x0, receiver data at +0x4, transmitter control at +0x8, transmitter data at +0xC. Any other address, including a non-word-aligned one, reads as zero, and a write to it changes nothing.
- R2: Control words use bit 0 for ready (read-only) and bit 1 for interrupt enable (read/write). Receiver control bit 2 is the overrun flag. All other bits read zero. Writing a control word changes only its enable bit.
- R3: A keystroke strobe stores its byte and sets receiver ready. A read of receiver data returns the byte in bits 7:0, with bits 31:8 zero, and clears ready at the end of that cycle.
- R4: A keystroke that arrives while receiver ready is 1 (and the data is not being read in that cycle) overwrites the byte and sets overrun. The next receiver control read returns overrun as 1 and clears it.
- R5: If a keystroke and a receiver data read fall in the same cycle, the read returns the old byte, the new byte is held, ready stays 1, and overrun is not set.
- R6: A transmitter data write while transmitter ready is 1 drives the display strobe high for exactly the next cycle, with bits 7:0 of the write on the display byte, and drops ready.
- R7: Transmitter ready stays 0 while the display reports busy. It returns to 1 one clock edge after busy is sampled low, and no earlier than two edges after the accepted write.
- R8: A transmitter data write while transmitter ready is 0 is discarded. No strobe follows it, and the byte is never sent.
- R9: Each interrupt request output is high exactly when that direction's ready and enable bits are both 1.
- R10: After reset, receiver ready is 0, transmitter ready is 1, both enables and overrun are 0, and the display strobe and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (32) | Byte address from the processor |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | CHAR_W (8) | Low byte of the write data; upper bits have no storage |
| bus_rdata | output | WORD_W (32) | Read data, valid while bus_rd is high, zero otherwise |
| key_valid | input | 1 | One-cycle keystroke strobe |
| key_byte | input | CHAR_W (8) | Keystroke character |
| disp_valid | output | 1 | One-cycle strobe toward the display |
| disp_byte | output | CHAR_W (8) | Character toward the display |
| disp_busy | input | 1 | Display still writing the previous character |
| rx_irq | output | 1 | Receiver interrupt request (level) |
| tx_irq | output | 1 | Transmitter interrupt request (level) |

## Verification
Two receive-side events can fall in the same cycle: a keystroke arriving and the processor reading receiver data. The bench provokes this by raising the keystroke strobe and the data read in one cycle. It then expects the read to return the previous byte, and a following control read to show ready set with overrun clear, before the new byte is read back. A second collision is the transmit write landing while the display is still busy. It is judged by the absence of any display strobe in the following cycle and by the next accepted character being the one sent.

// File: rtl/term_pkg.sv
package term_pkg;
    localparam int CHAR_W = 8;
    localparam int WORD_W = 32;
    localparam int NREG   = 4;
    localparam int SEL_W  = $clog2(NREG);

    // register slot order follows the address offsets
    typedef enum logic [SEL_W-1:0] {
        SEL_RXCTL = 2'd0,
        SEL_RXDAT = 2'd1,
        SEL_TXCTL = 2'd2,
        SEL_TXDAT = 2'd3
    } term_sel_e;

    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic              ovr;
        logic [CHAR_W-1:0] data;
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_phase_e;

    typedef struct packed {
        tx_phase_e         phase;
        logic              ie;
        logic [CHAR_W-1:0] data;
    } tx_state_t;
endpackage

// File: rtl/term_decode.sv
module term_decode
    import term_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = ADDR_W'(32'hFFFF_0000)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [NREG-1:0]   rd_stb,
    output logic [NREG-1:0]   wr_stb
);
    localparam int LSB = SEL_W + 2;

    logic hit;
    assign hit = (bus_addr[ADDR_W-1:LSB] == BASE[ADDR_W-1:LSB]) &&
                 (bus_addr[1:0] == 2'b00);

    for (genvar g = 0; g < NREG; g++) begin : g_stb
        assign rd_stb[g] = bus_rd && hit && (bus_addr[LSB-1:2] == SEL_W'(g));
        assign wr_stb[g] = bus_wr && hit && (bus_addr[LSB-1:2] == SEL_W'(g));
    end
endmodule

// File: rtl/term_rx.sv
module term_rx
    import term_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    input  logic              rd_ctl,
    input  logic              rd_dat,
    input  logic              wr_ctl,
    input  logic              wr_ie,
    output logic              rdy,
    output logic              ie,
    output logic              ovr,
    output logic [CHAR_W-1:0] data,
    output logic              irq
);
    rx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) st_d.ie  = wr_ie;
        if (rd_ctl) st_d.ovr = 1'b0;
        if (rd_dat) st_d.rdy = 1'b0;
        if (key_valid) begin
            st_d.data = key_byte;
            st_d.rdy  = 1'b1;
            // an unread byte is lost only if it is not consumed this cycle
            if (st_q.rdy && !rd_dat) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy  = st_q.rdy;
    assign ie   = st_q.ie;
    assign ovr  = st_q.ovr;
    assign data = st_q.data;
    assign irq  = st_q.rdy & st_q.ie;
endmodule

// File: rtl/term_tx.sv
module term_tx
    import term_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_dat,
    input  logic              wr_ie,
    input  logic [CHAR_W-1:0] wr_byte,
    input  logic              disp_busy,
    output logic              rdy,
    output logic              ie,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    output logic              irq
);
    tx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) st_d.ie = wr_ie;
        unique case (st_q.phase)
            TX_IDLE: if (wr_dat) begin
                st_d.data  = wr_byte;
                st_d.phase = TX_SEND;
            end
            TX_SEND: st_d.phase = TX_WAIT;
            TX_WAIT: if (!disp_busy) st_d.phase = TX_IDLE;
            default: st_d.phase = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: TX_IDLE, ie: 1'b0, data: '0};
        else        st_q <= st_d;
    end

    assign rdy        = (st_q.phase == TX_IDLE);
    assign ie         = st_q.ie;
    assign disp_valid = (st_q.phase == TX_SEND);
    assign disp_byte  = st_q.data;
    assign irq        = rdy & st_q.ie;
endmodule

// File: rtl/term_mmio.sv
module term_mmio
    import term_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = ADDR_W'(32'hFFFF_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CHAR_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_busy,
    output logic              rx_irq,
    output logic              tx_irq
);
    logic [NREG-1:0]   rd_stb, wr_stb;
    logic              rx_rdy, rx_ie, rx_ovr;
    logic [CHAR_W-1:0] rx_data;
    logic              tx_rdy, tx_ie;

    term_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb)
    );

    term_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_byte  (key_byte),
        .rd_ctl    (rd_stb[SEL_RXCTL]),
        .rd_dat    (rd_stb[SEL_RXDAT]),
        .wr_ctl    (wr_stb[SEL_RXCTL]),
        .wr_ie     (bus_wdata[1]),
        .rdy       (rx_rdy),
        .ie        (rx_ie),
        .ovr       (rx_ovr),
        .data      (rx_data),
        .irq       (rx_irq)
    );

    term_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl     (wr_stb[SEL_TXCTL]),
        .wr_dat     (wr_stb[SEL_TXDAT]),
        .wr_ie      (bus_wdata[1]),
        .wr_byte    (bus_wdata),
        .disp_busy  (disp_busy),
        .rdy        (tx_rdy),
        .ie         (tx_ie),
        .disp_valid (disp_valid),
        .disp_byte  (disp_byte),
        .irq        (tx_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_stb[SEL_RXCTL]) bus_rdata[2:0]        = {rx_ovr, rx_ie, rx_rdy};
        if (rd_stb[SEL_RXDAT]) bus_rdata[CHAR_W-1:0] = rx_data;
        if (rd_stb[SEL_TXCTL]) bus_rdata[1:0]        = {tx_ie, tx_rdy};
        if (rd_stb[SEL_TXDAT]) bus_rdata[CHAR_W-1:0] = disp_byte;
    end
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk
    import term_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = ADDR_W'(32'hFFFF_0000)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [CHAR_W-1:0] bus_wdata,
    input logic              key_valid,
    input logic              disp_valid,
    input logic [CHAR_W-1:0] disp_byte,
    input logic              disp_busy,
    input logic              rx_irq,
    input logic              tx_irq,
    input logic              rx_rdy,
    input logic              tx_rdy
);
    logic rd_rxdat, wr_txdat;
    assign rd_rxdat = bus_rd && (bus_addr == BASE + ADDR_W'(4));
    assign wr_txdat = bus_wr && (bus_addr == BASE + ADDR_W'(12));

    // R3
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxdat && !key_valid) |=> !rx_rdy);

    // R3
    key_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> rx_rdy);

    // R6
    tx_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txdat && tx_rdy) |=> (disp_valid && !tx_rdy && disp_byte == $past(bus_wdata)));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_rdy && disp_busy) |=> !tx_rdy);

    // R8
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txdat && !tx_rdy) |=> !disp_valid);

    // R9
    rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_rdy);

    // R9
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_rdy);
endmodule

bind term_mmio term_mmio_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .key_valid  (key_valid),
    .disp_valid (disp_valid),
    .disp_byte  (disp_byte),
    .disp_busy  (disp_busy),
    .rx_irq     (rx_irq),
    .tx_irq     (tx_irq),
    .rx_rdy     (rx_rdy),
    .tx_rdy     (tx_rdy)
);

// File: tb/sim_term_mmio.sv
`timescale 1ns/1ps
module sim_term_mmio;
    localparam logic [31:0] RXCTL = 32'hFFFF_0000;
    localparam logic [31:0] RXDAT = 32'hFFFF_0004;
    localparam logic [31:0] TXCTL = 32'hFFFF_0008;
    localparam logic [31:0] TXDAT = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        key_valid = 1'b0;
    logic [7:0]  key_byte = '0;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic        disp_busy = 1'b0;
    logic        rx_irq, tx_irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    term_mmio u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_valid(key_valid), .key_byte(key_byte), .disp_valid(disp_valid),
        .disp_byte(disp_byte), .disp_busy(disp_busy), .rx_irq(rx_irq),
        .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] b);
        @(posedge clk); #1;
        key_valid = 1'b1; key_byte = b;
        @(posedge clk); #1;
        key_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R10 disp_valid", {31'b0, disp_valid}, 32'd0);
        chk("R10 irqs", {30'b0, rx_irq, tx_irq}, 32'd0);
        rd(RXCTL, v); chk("R10 rx ctl", v, 32'h0);
        rd(TXCTL, v); chk("R10 tx ctl", v, 32'h1);
    endtask

    task automatic t_map;
        logic [31:0] v;
        rd(32'hFFFF_0010, v); chk("R1 out of range read", v, 32'h0);
        rd(32'hFFFF_0009, v); chk("R1 misaligned read", v, 32'h0);
        wr(32'h0000_0008, 8'h02);
        chk("R1 foreign write irq", {31'b0, tx_irq}, 32'd0);
        rd(TXCTL, v); chk("R1 foreign write ignored", v, 32'h1);
    endtask

    task automatic t_ctl_fields;
        logic [31:0] v;
        wr(RXCTL, 8'hFF);
        rd(RXCTL, v); chk("R2 rx ctl only enable", v, 32'h2);
        wr(TXCTL, 8'hFD);
        rd(TXCTL, v); chk("R2 tx ctl no enable", v, 32'h1);
        wr(RXCTL, 8'h00);
        rd(RXCTL, v); chk("R2 rx enable cleared", v, 32'h0);
    endtask

    task automatic t_rx_basic;
        logic [31:0] v;
        key(8'h41);
        rd(RXCTL, v); chk("R3 ready after key", v, 32'h1);
        rd(RXDAT, v); chk("R3 data read", v, 32'h41);
        rd(RXCTL, v); chk("R3 ready cleared", v, 32'h0);
    endtask

    task automatic t_overrun;
        logic [31:0] v;
        key(8'h42);
        key(8'h43);
        rd(RXCTL, v); chk("R4 overrun set", v, 32'h5);
        rd(RXCTL, v); chk("R4 overrun cleared by read", v, 32'h1);
        rd(RXDAT, v); chk("R4 newest byte kept", v, 32'h43);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        key(8'h10);
        @(posedge clk); #1;
        bus_addr = RXDAT; bus_rd = 1'b1; key_valid = 1'b1; key_byte = 8'h5A;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; key_valid = 1'b0;
        chk("R5 read returns old byte", v, 32'h10);
        rd(RXCTL, v); chk("R5 ready kept, no overrun", v, 32'h1);
        rd(RXDAT, v); chk("R5 new byte held", v, 32'h5A);
    endtask

    task automatic t_tx;
        logic [31:0] v;
        wr(TXDAT, 8'hA5);
        chk("R6 strobe after write", {31'b0, disp_valid}, 32'd1);
        chk("R6 display byte", {24'b0, disp_byte}, 32'hA5);
        disp_busy = 1'b1;
        @(posedge clk); #1;
        chk("R6 strobe one cycle", {31'b0, disp_valid}, 32'd0);
        rd(TXCTL, v); chk("R7 not ready while busy", v, 32'h0);
        wr(TXDAT, 8'h33);
        chk("R8 write while busy dropped", {31'b0, disp_valid}, 32'd0);
        repeat (3) @(posedge clk);
        #1;
        rd(TXCTL, v); chk("R7 still busy", v, 32'h0);
        disp_busy = 1'b0;
        @(posedge clk); #1;
        rd(TXCTL, v); chk("R7 ready after busy low", v, 32'h1);
        wr(TXDAT, 8'h7E);
        chk("R8 next char is the new one", {23'b0, disp_valid, disp_byte}, 32'h17E);
    endtask

    task automatic t_irq;
        wr(TXCTL, 8'h02);
        chk("R9 tx irq enabled", {31'b0, tx_irq}, 32'd1);
        wr(TXDAT, 8'h21);
        chk("R9 tx irq low after send", {31'b0, tx_irq}, 32'd0);
        @(posedge clk); #1;
        chk("R7 not ready one edge after write", {31'b0, tx_irq}, 32'd0);
        @(posedge clk); #1;
        chk("R7 ready two edges after write", {31'b0, tx_irq}, 32'd1);
        wr(RXCTL, 8'h02);
        chk("R9 rx irq idle", {31'b0, rx_irq}, 32'd0);
        key(8'h11);
        chk("R9 rx irq on key", {31'b0, rx_irq}, 32'd1);
        begin
            logic [31:0] v;
            rd(RXDAT, v);
            chk("R3 irq data", v, 32'h11);
        end
        chk("R9 rx irq cleared by read", {31'b0, rx_irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_map();
        t_ctl_fields();
        t_rx_basic();
        t_overrun();
        t_collide();
        t_tx();
        t_irq();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule